// File: doc/BRIEF.md
# Crystal-Clocked Binary Base Timer

This block is a free-running binary divider for a 32.768 kHz timebase. A 14-bit counter advances once for every enable pulse of the selected clock source. The source is a crystal tick, the system clock enable or the output tick of a companion prescaler. When the count wraps it raises a sticky overflow flag. With the crystal source this happens every 16384 ticks, which is 500 ms and suits clock-keeping software. A second sticky flag marks a faster period taken from one of four divider taps. With the crystal source the tap periods are about 976 µs, 3.9 ms, 15.6 ms and 62.5 ms.

Both flags stay set until software writes a one-cycle clear pulse. The two flags are ORed with an external interrupt input into a single vector request, because the timer shares its interrupt vector with that external line. A counter clear restarts the division phase and leaves pending flags alone. The oscillator itself and any calendar arithmetic belong to other blocks.

Top module: `xtal_base_timer`

## Requirements
- R1: After the asynchronous active-low reset, `count` is 0 and `ovfFlag`, `tapFlag` and `vectorReq` are 0 (with `extIrqIn` low).
- R2: A step happens in a cycle where `runEn` is 1 and the tick selected by `srcSel` is 1. The `srcSel` codes are 00 crystal tick, 01 system tick, 10 prescaler tick and 11 no source. A step without `cntClear` raises `count` by exactly one, modulo 16384, at the next clock edge. A tick of a non-selected source changes nothing.
- R3: While `runEn` is 0, `count` holds its value whatever the ticks do, unless `cntClear` is applied.
- R4: A step taken from count 16383 makes `count` 0 and sets `ovfFlag` at the same edge.
- R5: `tapSel` picks the divider bit as follows: 00 is bit 5, 01 is bit 7, 10 is bit 9 and 11 is bit 11. `tapFlag` sets at the edge of each step that changes that bit, which is when all bits below it are ones. Counting from a cleared counter, this is first on step 32, 128, 512 or 2048.
- R6: Each flag stays set until its own clear pulse (`ovfClr`, `tapClr`). A clear pulse drops the flag at the next edge. A new set event in the same cycle as the clear wins, so the flag stays 1.
- R7: `cntClear` forces `count` to 0 at the next edge. It takes priority over a step in the same cycle, and that step sets no flag. It does not change either flag.
- R8: A change of `srcSel` adds no count of its own. Counting follows the tick of the newly selected source from the same cycle in which it is selected.
- R9: `vectorReq` is 1 whenever `ovfFlag`, `tapFlag` or `extIrqIn` is 1, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xtalTick | input | 1 | One-cycle enable from the 32.768 kHz crystal domain |
| sysTick | input | 1 | System clock count enable |
| preTick | input | 1 | Enable pulse from the companion timer's prescaler |
| srcSel | input | 2 | Clock source select (00 crystal, 01 system, 10 prescaler, 11 none) |
| tapSel | input | 2 | Fast-period tap select (00 bit 5, 01 bit 7, 10 bit 9, 11 bit 11) |
| runEn | input | 1 | Count enable |
| cntClear | input | 1 | Synchronous counter clear |
| ovfClr | input | 1 | Write-one pulse that clears the overflow flag |
| tapClr | input | 1 | Write-one pulse that clears the tap flag |
| extIrqIn | input | 1 | External interrupt request sharing the vector |
| count | output | 14 | Current divider value |
| ovfFlag | output | 1 | Sticky full-period overflow flag |
| tapFlag | output | 1 | Sticky fast-tap flag |
| vectorReq | output | 1 | Combined request for the shared interrupt vector |

## Verification
The assertions assume that every input is synchronous to `clk` and settled at the sampling edge. They also assume that a tick is a plain level and that its pulse shape is not checked, so a tick held high for several cycles is read as one step per cycle. The bench drives every input just after a rising edge. Its random phases toggle the ticks, sources, taps and clear pulses at mixed rates, so that sources switch while ticks are active and clears collide with set events. Long directed runs on the system tick reach the overflow and each tap boundary exactly.

// File: rtl/base_timer_pkg.sv
package base_timer_pkg;

  // width of the tap select field (four taps)
  localparam int TAP_SEL_W = 2;
  localparam int TAP_N     = 1 << TAP_SEL_W;

  // clock source codes
  typedef enum logic [1:0] {
    SRC_XTAL = 2'b00,
    SRC_SYS  = 2'b01,
    SRC_PRE  = 2'b10,
    SRC_NONE = 2'b11
  } srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             step;
    logic             clear;
    logic [TAP_N-1:0] tapOneHot;
    logic             ovfClr;
    logic             tapClr;
  } btmrStrobe_t;

endpackage

// File: rtl/btmr_ctrl.sv
module btmr_ctrl
  import base_timer_pkg::*;
(
  input  logic                 xtalTick,
  input  logic                 sysTick,
  input  logic                 preTick,
  input  logic [1:0]           srcSel,
  input  logic [TAP_SEL_W-1:0] tapSel,
  input  logic                 runEn,
  input  logic                 cntClear,
  input  logic                 ovfClr,
  input  logic                 tapClr,
  output btmrStrobe_t          strobe
);

  logic srcTick;

  // the mux is purely combinational, so a source switch counts the new
  // source's pulse in the same cycle and never inserts a step of its own
  always_comb begin
    unique case (srcSel_e'(srcSel))
      SRC_XTAL: srcTick = xtalTick;
      SRC_SYS:  srcTick = sysTick;
      SRC_PRE:  srcTick = preTick;
      default:  srcTick = 1'b0;
    endcase
  end

  logic [TAP_N-1:0] tapDec;

  always_comb begin
    tapDec = '0;
    tapDec[tapSel] = 1'b1;
  end

  always_comb begin
    strobe.step      = runEn & srcTick;
    strobe.clear     = cntClear;
    strobe.tapOneHot = tapDec;
    strobe.ovfClr    = ovfClr;
    strobe.tapClr    = tapClr;
  end

endmodule

// File: rtl/btmr_datapath.sv
module btmr_datapath
  import base_timer_pkg::*;
#(
  parameter int CNT_W      = 14,
  parameter int TAP_BASE   = 5,
  parameter int TAP_STRIDE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  btmrStrobe_t       strobe,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              tapFlag
);

  logic [TAP_N-1:0] lowOnes;

  // carry into tap bit b: all bits below b are ones
  for (genvar i = 0; i < TAP_N; i++) begin : g_tap
    localparam int B = TAP_BASE + TAP_STRIDE * i;
    assign lowOnes[i] = &count[B-1:0];
  end

  logic stepLive;
  logic ovfSet;
  logic tapSet;

  assign stepLive = strobe.step & ~strobe.clear;
  assign ovfSet   = stepLive & (&count);
  assign tapSet   = stepLive & (|(lowOnes & strobe.tapOneHot));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clear) begin
      count <= '0;
    end else if (strobe.step) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      tapFlag <= 1'b0;
    end else begin
      ovfFlag <= ovfSet | (ovfFlag & ~strobe.ovfClr);
      tapFlag <= tapSet | (tapFlag & ~strobe.tapClr);
    end
  end

endmodule

// File: rtl/xtal_base_timer.sv
module xtal_base_timer
  import base_timer_pkg::*;
#(
  parameter int CNT_W      = 14,
  parameter int TAP_BASE   = 5,
  parameter int TAP_STRIDE = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 xtalTick,
  input  logic                 sysTick,
  input  logic                 preTick,
  input  logic [1:0]           srcSel,
  input  logic [TAP_SEL_W-1:0] tapSel,
  input  logic                 runEn,
  input  logic                 cntClear,
  input  logic                 ovfClr,
  input  logic                 tapClr,
  input  logic                 extIrqIn,
  output logic [CNT_W-1:0]     count,
  output logic                 ovfFlag,
  output logic                 tapFlag,
  output logic                 vectorReq
);

  btmrStrobe_t strobe;

  btmr_ctrl u_ctrl (
    .xtalTick (xtalTick),
    .sysTick  (sysTick),
    .preTick  (preTick),
    .srcSel   (srcSel),
    .tapSel   (tapSel),
    .runEn    (runEn),
    .cntClear (cntClear),
    .ovfClr   (ovfClr),
    .tapClr   (tapClr),
    .strobe   (strobe)
  );

  btmr_datapath #(
    .CNT_W      (CNT_W),
    .TAP_BASE   (TAP_BASE),
    .TAP_STRIDE (TAP_STRIDE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .count   (count),
    .ovfFlag (ovfFlag),
    .tapFlag (tapFlag)
  );

  // shared vector with the external interrupt line
  assign vectorReq = ovfFlag | tapFlag | extIrqIn;

endmodule

// File: rtl/btmr_checker.sv
module btmr_checker #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             sysTick,
  input logic [1:0]       srcSel,
  input logic             runEn,
  input logic             cntClear,
  input logic             ovfClr,
  input logic             tapClr,
  input logic [CNT_W-1:0] count,
  input logic             ovfFlag,
  input logic             tapFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && srcSel == 2'b01 && sysTick && !cntClear)
      |=> count == CNT_W'($past(count) + 1'b1));

  p_none_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b11 && !cntClear) |=> $stable(count));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cntClear) |=> $stable(count));

  p_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && srcSel == 2'b01 && sysTick && !cntClear && count == CNT_MAX)
      |=> (ovfFlag && count == '0));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  p_tap_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tapFlag && !tapClr) |=> tapFlag);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    cntClear |=> count == '0);

  p_clear_no_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cntClear && !ovfFlag) |=> !ovfFlag);

endmodule

bind xtal_base_timer btmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sysTick  (sysTick),
  .srcSel   (srcSel),
  .runEn    (runEn),
  .cntClear (cntClear),
  .ovfClr   (ovfClr),
  .tapClr   (tapClr),
  .count    (count),
  .ovfFlag  (ovfFlag),
  .tapFlag  (tapFlag)
);

// File: tb/tb_xtal_base_timer.sv
`timescale 1ns/1ps
module tb_xtal_base_timer;

  localparam int CNT_W = 14;
  localparam int CNT_MOD = 1 << CNT_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xtalTick = 0, sysTick = 0, preTick = 0;
  logic [1:0] srcSel = 2'b00;
  logic [1:0] tapSel = 2'b00;
  logic runEn = 0, cntClear = 0, ovfClr = 0, tapClr = 0, extIrqIn = 0;
  logic [CNT_W-1:0] count;
  logic ovfFlag, tapFlag, vectorReq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xtal_base_timer dut (
    .clk(clk), .rstN(rstN), .xtalTick(xtalTick), .sysTick(sysTick),
    .preTick(preTick), .srcSel(srcSel), .tapSel(tapSel), .runEn(runEn),
    .cntClear(cntClear), .ovfClr(ovfClr), .tapClr(tapClr),
    .extIrqIn(extIrqIn), .count(count), .ovfFlag(ovfFlag),
    .tapFlag(tapFlag), .vectorReq(vectorReq)
  );

  // ---------------- reference model from the requirements ----------------
  int mCount = 0;
  bit mOvf = 0, mTap = 0;

  function automatic bit srcTickOf(logic [1:0] s, logic x, logic y, logic p);
    case (s)
      2'b00:   return x;
      2'b01:   return y;
      2'b10:   return p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int tapBitOf(logic [1:0] t);
    return 5 + 2 * int'(t);
  endfunction

  function automatic bit tapHit(int c, logic [1:0] t);
    int mask;
    mask = (1 << tapBitOf(t)) - 1;
    return (c & mask) == mask;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount = 0; mOvf = 0; mTap = 0;
    end else begin
      bit st, nOvf, nTap;
      st   = runEn && srcTickOf(srcSel, xtalTick, sysTick, preTick) && !cntClear;
      nOvf = st && (mCount == CNT_MOD - 1);
      nTap = st && tapHit(mCount, tapSel);
      mOvf = nOvf | (mOvf & !ovfClr);
      mTap = nTap | (mTap & !tapClr);
      if (cntClear) mCount = 0;
      else if (st) mCount = (mCount + 1) % CNT_MOD;
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // advance one edge, then compare against the model away from the edge
  task automatic cyc();
    @(posedge clk);
    #1;
    check("R2 count", int'(count), mCount);
    check("R4 ovfFlag", int'(ovfFlag), int'(mOvf));
    check("R5 tapFlag", int'(tapFlag), int'(mTap));
    check("R9 vectorReq", int'(vectorReq), int'(mOvf | mTap | extIrqIn));
  endtask

  task automatic idle();
    xtalTick = 0; sysTick = 0; preTick = 0;
    cntClear = 0; ovfClr = 0; tapClr = 0; extIrqIn = 0;
  endtask

  task automatic restart();
    idle();
    cntClear = 1; ovfClr = 1; tapClr = 1;
    cyc();
    idle();
  endtask

  task automatic randomPhase(int n);
    for (int i = 0; i < n; i++) begin
      xtalTick = ($urandom % 3) == 0;
      sysTick  = ($urandom % 2) == 0;
      preTick  = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) srcSel = 2'($urandom);
      if (($urandom % 64) == 0) tapSel = 2'($urandom);
      runEn    = ($urandom % 8) != 0;
      cntClear = ($urandom % 500) == 0;
      ovfClr   = ($urandom % 40) == 0;
      tapClr   = ($urandom % 6) == 0;
      extIrqIn = ($urandom % 10) == 0;
      cyc();
    end
    idle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 count", int'(count), 0);
    check("R1 ovfFlag", int'(ovfFlag), 0);
    check("R1 tapFlag", int'(tapFlag), 0);
    check("R1 vectorReq", int'(vectorReq), 0);
    rstN = 1;
    cyc();

    // R3 runEn low holds
    runEn = 0; srcSel = 2'b01; sysTick = 1; xtalTick = 1; preTick = 1;
    repeat (10) cyc();
    check("R3 hold", int'(count), 0);

    // R2 reserved source never counts
    runEn = 1; srcSel = 2'b11;
    repeat (6) cyc();
    check("R2 no source", int'(count), 0);

    // R8 source switch: no extra count, new source from the same cycle
    idle(); srcSel = 2'b00; sysTick = 1;
    repeat (5) cyc();
    check("R8 other source ignored", int'(count), 0);
    srcSel = 2'b01;
    cyc();
    check("R8 switch count", int'(count), 1);
    srcSel = 2'b10; sysTick = 1; preTick = 0;
    cyc();
    check("R8 after switch to prescaler", int'(count), 1);
    preTick = 1;
    cyc();
    check("R8 prescaler tick", int'(count), 2);
    idle();

    // R5 each tap boundary
    for (int t = 0; t < 4; t++) begin
      tapSel = 2'(t);
      restart();
      srcSel = 2'b01; runEn = 1; sysTick = 1;
      repeat ((1 << tapBitOf(2'(t))) - 1) cyc();
      check("R5 tap not yet", int'(tapFlag), 0);
      cyc();
      check("R5 tap set", int'(tapFlag), 1);
      idle();
    end

    // R4 overflow after 16384 steps
    restart();
    srcSel = 2'b01; runEn = 1; sysTick = 1;
    repeat (CNT_MOD - 1) cyc();
    check("R4 before wrap", int'(ovfFlag), 0);
    check("R4 top count", int'(count), CNT_MOD - 1);
    cyc();
    check("R4 wrap flag", int'(ovfFlag), 1);
    check("R4 wrap count", int'(count), 0);

    // R7 clear beats step, keeps flags
    sysTick = 1; cntClear = 1;
    cyc();
    check("R7 count zero", int'(count), 0);
    check("R7 flag kept", int'(ovfFlag), 1);
    idle();

    // R6 sticky, clear pulse drops flag
    repeat (3) cyc();
    check("R6 sticky", int'(ovfFlag), 1);
    ovfClr = 1;
    cyc();
    check("R6 clear", int'(ovfFlag), 0);
    idle();

    // R6 set wins over simultaneous clear (tap bit 5, 32 steps)
    tapSel = 2'b00;
    restart();
    sysTick = 1; runEn = 1; srcSel = 2'b01;
    repeat (32) cyc();
    check("R6 tap set", int'(tapFlag), 1);
    repeat (31) cyc();
    tapClr = 1;
    cyc();
    check("R6 set wins over clear", int'(tapFlag), 1);
    idle();

    // R9 external line alone
    restart();
    extIrqIn = 1;
    #1;
    check("R9 external only", int'(vectorReq), 1);
    cyc();
    idle();

    randomPhase(20000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule